// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Separate Placement Address

This block is a read-only, direct-mapped data cache in which every load carries two addresses. The placement address picks the set. The real address supplies the tag, selects the word within the line and is the only address that ever goes out on the refill port. An ordinary load drives the same value on both. A remapped load drives a placement address that is shifted by some offset, usually one line (real address plus 32). Two arrays that would otherwise fight over the same sets can then be spread across different sets. The placement address need not be a valid memory address, and it is never sent to memory.

The default geometry is 16 KB in 32-byte lines, which gives 512 sets. The set index is taken from placement bits [13:5], the tag is real bits [31:5], and the word select is real bits [4:2]. A hit needs the valid bit and a tag match against the real line address, so placing a line in an unexpected set can cost a miss but can never return wrong data. A hit answers one cycle after the request is accepted, whichever kind of load it is. A miss sends one refill request, takes eight 32-bit beats, writes the line into the set chosen by the placement address, and then answers.

Top module: `twin_dcache`

## Requirements
- R1: After a synchronous reset, `req_ready` is 1, `rsp_valid` and `mem_req_valid` are 0, and every set is invalid, so the first load to any line misses.
- R2: The set index is placement address bits [13:5]. Placement bits [4:0] and [31:14] have no effect on which set is used.
- R3: `mem_req_addr` always equals the real address of the missing load with bits [4:0] cleared. The placement address never appears on it.
- R4: A refill takes exactly eight beats on `mem_rsp_valid`. Beat n holds the word at line offset 4n. `rsp_data` returns the word selected by real address bits [4:2].
- R5: A hit raises `rsp_valid` in the cycle after acceptance, with no refill request. The latency is the same for ordinary and remapped loads.
- R6: A miss raises `mem_req_valid` in the cycle after acceptance. `req_ready` stays 0 until the response cycle, and `rsp_valid` rises in the cycle after the eighth beat, 10 cycles after acceptance.
- R7: A hit needs a valid set whose tag equals real bits [31:5]. A load whose placement set holds a different real line misses and returns the data of its own real address.
- R8: Two streams whose base addresses differ by a multiple of 16 KB miss on every alternating ordinary load. When one of the streams uses placement = real + 32, each line misses at most once and then hits.
- R9: `mem_req_valid` is a single-cycle pulse, issued once per miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Load request present |
| req_ready | output | 1 | Cache can accept a load |
| req_place_addr | input | 32 | Placement address, selects the set |
| req_real_addr | input | 32 | Real byte address, supplies the tag and word select |
| rsp_valid | output | 1 | Load data valid |
| rsp_data | output | 32 | Loaded word |
| mem_req_valid | output | 1 | Refill request pulse |
| mem_req_addr | output | 32 | Real line address to refill |
| mem_rsp_valid | input | 1 | Refill beat present |
| mem_rsp_data | input | 32 | Refill beat word |

## Verification
The first stimulus is a pair of streams 16 KB apart, loaded alternately. With ordinary loads every access misses, and after one stream is remapped by a line only the first touch of each line misses. Comparing the two runs separates correct set selection from accidental reuse. Aliasing loads share a placement set but carry different real lines. They show that the tag, not the set, decides a hit. Remapped loads whose placement address differs only in the low or high bits show which bits form the index. A seeded random mix of ordinary, line-shifted and arbitrary placement addresses, checked against a bench shadow of tags, covers hit/miss order, word select and refill addressing under mixed traffic.

// File: rtl/twin_dcache.sv
module twin_dcache #(
  parameter int ADDR_W      = 32,
  parameter int WORD_W      = 32,
  parameter int LINE_BYTES  = 32,
  parameter int CACHE_BYTES = 16384
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_place_addr,
  input  logic [ADDR_W-1:0] req_real_addr,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_data,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [WORD_W-1:0] mem_rsp_data
);
  localparam int WORD_BYTES = WORD_W / 8;
  localparam int WORDS      = LINE_BYTES / WORD_BYTES;
  localparam int SETS       = CACHE_BYTES / LINE_BYTES;
  localparam int OFF_W      = $clog2(LINE_BYTES);
  localparam int BYTE_W     = $clog2(WORD_BYTES);
  localparam int SEL_W      = $clog2(WORDS);
  localparam int IDX_W      = $clog2(SETS);
  localparam int TAG_W      = ADDR_W - OFF_W;
  localparam int LINE_W     = WORD_W * WORDS;

  logic [SETS-1:0]   valid_q;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [LINE_W-1:0] data_q [SETS];

  logic              pend_q;
  logic [IDX_W-1:0]  pend_idx_q;
  logic [ADDR_W-1:0] pend_real_q;
  logic              filling_q;
  logic [SEL_W-1:0]  beat_q;
  logic [LINE_W-1:0] fill_q;

  logic [LINE_W-1:0] fill_line;
  logic [LINE_W-1:0] cur_line;
  logic [SEL_W-1:0]  word_sel;
  logic              tag_eq;
  logic              hit;
  logic              miss;
  logic              last_beat;

  assign tag_eq    = tag_q[pend_idx_q] == pend_real_q[ADDR_W-1:OFF_W];
  assign hit       = !filling_q && pend_q && valid_q[pend_idx_q] && tag_eq;
  assign miss      = !filling_q && pend_q && !hit;
  assign last_beat = filling_q && mem_rsp_valid && (beat_q == SEL_W'(WORDS-1));
  assign fill_line = {mem_rsp_data, fill_q[LINE_W-1:WORD_W]};

  assign cur_line  = data_q[pend_idx_q];
  assign word_sel  = pend_real_q[OFF_W-1:BYTE_W];

  assign req_ready     = !filling_q && !miss;
  assign rsp_valid     = hit;
  assign rsp_data      = cur_line[word_sel*WORD_W +: WORD_W];
  assign mem_req_valid = miss;
  assign mem_req_addr  = {pend_real_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q   <= '0;
      pend_q    <= 1'b0;
      filling_q <= 1'b0;
      beat_q    <= '0;
    end else begin
      if (req_valid && req_ready)
        pend_q <= 1'b1;
      else if (hit)
        pend_q <= 1'b0;
      if (miss) begin
        filling_q <= 1'b1;
        beat_q    <= '0;
      end else if (filling_q && mem_rsp_valid) begin
        beat_q <= beat_q + 1'b1;
        if (last_beat) begin
          filling_q           <= 1'b0;
          valid_q[pend_idx_q] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (req_valid && req_ready) begin
      pend_idx_q  <= req_place_addr[OFF_W +: IDX_W];
      pend_real_q <= req_real_addr;
    end
    if (filling_q && mem_rsp_valid)
      fill_q <= fill_line;
    if (last_beat) begin
      tag_q[pend_idx_q]  <= pend_real_q[ADDR_W-1:OFF_W];
      data_q[pend_idx_q] <= fill_line;
    end
  end
endmodule

// File: rtl/twin_dcache_chk.sv
module twin_dcache_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_real_addr,
  input logic              rsp_valid,
  input logic              mem_req_valid,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_rsp_valid
);
  logic [ADDR_W-1:0] last_real_q;

  always_ff @(posedge clk) begin
    if (rst)
      last_real_q <= '0;
    else if (req_valid && req_ready)
      last_real_q <= req_real_addr;
  end

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (req_ready && !rsp_valid && !mem_req_valid)); // R1
  AST_REFILL_REAL_LINE: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> (mem_req_addr == {last_real_q[ADDR_W-1:5], 5'b0})); // R3
  AST_REFILL_PULSE: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |=> !mem_req_valid); // R9
  AST_BLOCKED_ON_MISS: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> (!req_ready && !rsp_valid)); // R6
  AST_BLOCKED_IN_FILL: assert property (@(posedge clk) disable iff (rst)
    mem_rsp_valid |-> (!req_ready && !rsp_valid)); // R6
endmodule

bind twin_dcache twin_dcache_chk u_chk (.*);

// File: tb/twin_dcache_test.sv
module twin_dcache_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_place_addr = '0;
  logic [31:0] req_real_addr = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        mem_req_valid;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  int checks = 0;
  int fails = 0;
  int refills = 0;
  int beats_left = 0;
  logic [31:0] beat_base = '0;
  logic [31:0] cur_real = '0;
  bit done = 0;

  logic        sh_valid [512];
  logic [26:0] sh_tag   [512];

  always #2 clk = ~clk;

  twin_dcache uut (.*);

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ {a[15:0], a[31:16]} ^ 32'hC0DE1234;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (beats_left > 0) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = mem_word(beat_base + 32'((8 - beats_left) * 4));
      beats_left--;
    end else begin
      mem_rsp_valid = 1'b0;
    end
    if (mem_req_valid) begin
      refills++;
      check(mem_req_addr == {cur_real[31:5], 5'b0}, "R3 refill address", mem_req_addr, {cur_real[31:5], 5'b0});
      beat_base  = mem_req_addr;
      beats_left = 8;
    end
  end

  // Issues one load; returns 1 if it missed
  task automatic load(input logic [31:0] place, input logic [31:0] real_a, output bit missed);
    int cyc;
    int r0;
    bit exp_hit;
    logic [8:0] idx;
    idx = place[13:5];
    exp_hit = sh_valid[idx] && sh_tag[idx] == real_a[31:5];
    while (!req_ready) @(negedge clk);
    r0 = refills;
    cur_real = real_a;
    req_valid = 1'b1;
    req_place_addr = place;
    req_real_addr = real_a;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1;
    while (!rsp_valid && cyc < 40) begin
      check(!req_ready, "R6 ready low while miss outstanding", 32'(req_ready), 32'd0);
      @(negedge clk);
      cyc++;
    end
    missed = refills != r0;
    check(rsp_data == mem_word({real_a[31:2], 2'b0}), "R4 R7 load data", rsp_data, mem_word({real_a[31:2], 2'b0}));
    check(missed == !exp_hit, "R2 R7 hit/miss against tag model", 32'(missed), 32'(!exp_hit));
    if (exp_hit) check(cyc == 1, "R5 hit latency", 32'(cyc), 32'd1);
    else         check(cyc == 10, "R6 miss latency", 32'(cyc), 32'd10);
    sh_valid[idx] = 1'b1;
    sh_tag[idx]   = real_a[31:5];
  endtask

  initial begin
    int miss_n;
    bit m;
    for (int i = 0; i < 512; i++) sh_valid[i] = 1'b0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(req_ready && !rsp_valid && !mem_req_valid, "R1 reset outputs", {req_ready, rsp_valid, mem_req_valid}, 32'b100);

    load(32'h100C, 32'h100C, m);
    check(m, "R1 first load misses", 32'(m), 32'd1);
    load(32'h1004, 32'h1004, m);
    check(!m, "R5 second word hits", 32'(m), 32'd0);

    miss_n = 0;
    for (int i = 0; i < 8; i++) begin
      load(32'h2000 + 32'(4*i), 32'h2000 + 32'(4*i), m); miss_n += int'(m);
      load(32'h6000 + 32'(4*i), 32'h6000 + 32'(4*i), m); miss_n += int'(m);
    end
    check(miss_n == 16, "R8 ordinary loads thrash", 32'(miss_n), 32'd16);

    miss_n = 0;
    for (int i = 0; i < 8; i++) begin
      load(32'h2000 + 32'(4*i), 32'h2000 + 32'(4*i), m); miss_n += int'(m);
      load(32'h6020 + 32'(4*i), 32'h6000 + 32'(4*i), m); miss_n += int'(m);
    end
    check(miss_n == 2, "R8 remapped loads stop conflicting", 32'(miss_n), 32'd2);

    load(32'h2000, 32'h9000, m);
    check(m, "R7 alias in same set misses", 32'(m), 32'd1);
    load(32'h601C, 32'h9004, m);
    check(!m, "R2 placement high and low bits ignored", 32'(m), 32'd0);
    load(32'h2000, 32'h2008, m);
    check(m, "R7 original line evicted by alias", 32'(m), 32'd1);

    for (int n = 0; n < 400; n++) begin
      logic [31:0] ra;
      logic [31:0] pa;
      int k;
      ra = {18'd0, 4'($urandom_range(0, 15)), 3'($urandom_range(0, 3)), 5'($urandom_range(0, 7) * 4)};
      k = int'($urandom_range(0, 2));
      pa = (k == 0) ? ra : (k == 1) ? ra + 32'd32 : $urandom();
      load(pa, ra, m);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule